// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches the write side of a parallel flash-style bus (an address, a 16-bit data word and a write strobe). It turns the multi-cycle, address-qualified command sequences written there into mode indications and operation requests for the rest of a flash controller. It tracks whether reads should return the array or the query table. It tracks whether the short bypass program mode is active. It issues one-cycle program requests carrying address and data, and one-cycle requests for each accepted erase block.

Block erase opens a collection window. Each further confirm write for a block in the same bank adds that block and restarts the window. When the window runs out with no further confirm, an erase start pulse is issued. A block from the other bank ends the whole erase with an abort pulse, and so does any other write during the window. In standard mode, a write that breaks an unlock sequence returns the decoder to read-array mode and raises no request. The window length in clock cycles and the bank boundary are parameters.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, mode_array is 1, the other three mode outputs are 0, and no request pulse is raised. Exactly one of mode_array, mode_cfi, mode_bypass and erase_pending is 1 at all times.
- R2: A standard sequence begins with data 00AAh at address 555h, followed by data 0055h at address 2AAh. Only the low 11 address bits take part in these comparisons.
- R3: A write of data 00F0h from read-array or query mode leaves the decoder in read-array mode.
- R4: A write of data 0098h from read-array or query mode enters query mode (mode_cfi). Query mode is held with no writes. The next write is decoded as it would be from read-array mode.
- R5: The two unlock writes, then 00A0h at 555h, then one write of any address and data, raise prog_req for exactly one cycle after that fourth write, with prog_addr and prog_data equal to it.
- R6: The two unlock writes followed by 0020h at 555h set mode_bypass. In bypass mode, 00A0h followed by any write issues a program request and bypass stays active. Any other single write that is not 0090h is ignored.
- R7: In bypass mode, 0090h followed by 0000h returns to read-array mode. 0090h followed by any other word leaves bypass active.
- R8: Unlock, 0080h at 555h, unlock again, then 0030h at a block address raises erase_blk_req for one cycle with erase_blk_addr equal to that address, and sets erase_pending.
- R9: While erase_pending, each 0030h write to a block in the same bank adds that block and restarts the window. erase_go pulses exactly WIN_CYCLES cycles after the clock edge that took the last confirm, and the decoder then returns to read-array mode.
- R10: A block belongs to the upper bank when its address is at least BANK_BOUND. While erase_pending, a 0030h write to the other bank, or any other write, raises erase_abort for one cycle, returns to read-array mode and suppresses erase_go.
- R11: In standard mode, a write whose address or data does not match the expected step returns the decoder to read-array mode with no request raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle strobe marking a bus write |
| wr_addr | input | AW | Write address |
| wr_data | input | 16 | Write data |
| mode_array | output | 1 | Reads return the memory array |
| mode_cfi | output | 1 | Reads return the query table |
| mode_bypass | output | 1 | Bypass program mode active |
| erase_pending | output | 1 | Erase block collection window open |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | AW | Program target address |
| prog_data | output | 16 | Program data word |
| erase_blk_req | output | 1 | One-cycle pulse, block added to the erase |
| erase_blk_addr | output | AW | Address of the block just added |
| erase_go | output | 1 | One-cycle pulse, collected erase begins |
| erase_abort | output | 1 | One-cycle pulse, collected erase dropped |

## Verification
The assertions assume that each bus write appears as wr_en high for exactly one clock with a stable address and data. They also assume WIN_CYCLES is at least 2, and that no write arrives in the very cycle the erase window runs out. The write task in the stimulus drives single-cycle strobes separated by an idle cycle. After the final confirm it either waits well past the window or deliberately writes well inside it, so the expiry cycle and a write never coincide.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int ULK_W = 11;
  localparam logic [ULK_W-1:0] ULK_ADDR_A = 11'h555;
  localparam logic [ULK_W-1:0] ULK_ADDR_B = 11'h2AA;

  localparam logic [15:0] D_KEY_A   = 16'h00AA;
  localparam logic [15:0] D_KEY_B   = 16'h0055;
  localparam logic [15:0] D_TO_ARR  = 16'h00F0;
  localparam logic [15:0] D_TO_QRY  = 16'h0098;
  localparam logic [15:0] D_PGM     = 16'h00A0;
  localparam logic [15:0] D_BYP_IN  = 16'h0020;
  localparam logic [15:0] D_ERS     = 16'h0080;
  localparam logic [15:0] D_ERS_OK  = 16'h0030;
  localparam logic [15:0] D_BYP_OUT = 16'h0090;
  localparam logic [15:0] D_BYP_OK  = 16'h0000;

  typedef enum logic [3:0] {
    ST_ARRAY, ST_QUERY, ST_KEY1, ST_KEY2, ST_PGM,
    ST_ER_K0, ST_ER_K1, ST_ER_K2, ST_ER_WIN,
    ST_BYP, ST_BYP_PGM, ST_BYP_OUT
  } fcd_state_e;
endpackage

// File: rtl/fcd_window_timer.sv
module fcd_window_timer #(
  parameter int WIN_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic clear,
  output logic expired
);
  localparam int CW = $clog2(WIN_CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(WIN_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (restart) begin
      cnt <= RELOAD;
      run <= 1'b1;
    end else if (clear) begin
      run <= 1'b0;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign expired = run && (cnt == '0);

  // R9: the window ends once, then stays closed until reloaded
  p_expire_once_r9: assert property (@(posedge clk) disable iff (rst)
    expired |=> !expired);
  // R9: a running window counts down by one per cycle
  p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
    (run && !restart && !clear && cnt != '0) |=> (run && cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/fcd_bank_tracker.sv
module fcd_bank_tracker #(
  parameter int AW = 21,
  parameter logic [AW-1:0] BANK_BOUND = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [AW-1:0] addr,
  output logic          same_bank
);
  logic held_upper;
  logic cur_upper;

  assign cur_upper = (addr >= BANK_BOUND);

  always_ff @(posedge clk) begin
    if (rst)          held_upper <= 1'b0;
    else if (capture) held_upper <= cur_upper;
  end

  assign same_bank = (cur_upper == held_upper);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int AW = 21,
  parameter int WIN_CYCLES = 5000,
  parameter logic [AW-1:0] BANK_BOUND = AW'(21'h180000)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  output logic          mode_array,
  output logic          mode_cfi,
  output logic          mode_bypass,
  output logic          erase_pending,
  output logic          prog_req,
  output logic [AW-1:0] prog_addr,
  output logic [15:0]   prog_data,
  output logic          erase_blk_req,
  output logic [AW-1:0] erase_blk_addr,
  output logic          erase_go,
  output logic          erase_abort
);
  fcd_state_e st, st_nxt;
  logic [ULK_W-1:0] low_addr;
  logic hit_a, hit_b;
  logic prog_n, blk_n, go_n, abort_n;
  logic win_restart, bank_capture, win_expired, same_bank;

  assign low_addr = wr_addr[ULK_W-1:0];
  assign hit_a = (low_addr == ULK_ADDR_A);
  assign hit_b = (low_addr == ULK_ADDR_B);

  fcd_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .restart(win_restart), .clear(abort_n),
    .expired(win_expired));

  fcd_bank_tracker #(.AW(AW), .BANK_BOUND(BANK_BOUND)) u_bank (
    .clk(clk), .rst(rst), .capture(bank_capture), .addr(wr_addr),
    .same_bank(same_bank));

  always_comb begin
    st_nxt       = st;
    prog_n       = 1'b0;
    blk_n        = 1'b0;
    go_n         = 1'b0;
    abort_n      = 1'b0;
    win_restart  = 1'b0;
    bank_capture = 1'b0;
    if (st == ST_ER_WIN && win_expired) begin
      go_n   = 1'b1;
      st_nxt = ST_ARRAY;
    end else if (wr_en) begin
      st_nxt = ST_ARRAY;
      unique case (st)
        ST_ARRAY, ST_QUERY: begin
          if (wr_data == D_TO_QRY)                st_nxt = ST_QUERY;
          else if (hit_a && wr_data == D_KEY_A)   st_nxt = ST_KEY1;
        end
        ST_KEY1: if (hit_b && wr_data == D_KEY_B) st_nxt = ST_KEY2;
        ST_KEY2: if (hit_a) begin
          if (wr_data == D_PGM)         st_nxt = ST_PGM;
          else if (wr_data == D_BYP_IN) st_nxt = ST_BYP;
          else if (wr_data == D_ERS)    st_nxt = ST_ER_K0;
        end
        ST_PGM: prog_n = 1'b1;
        ST_ER_K0: if (hit_a && wr_data == D_KEY_A) st_nxt = ST_ER_K1;
        ST_ER_K1: if (hit_b && wr_data == D_KEY_B) st_nxt = ST_ER_K2;
        ST_ER_K2: if (wr_data == D_ERS_OK) begin
          blk_n        = 1'b1;
          win_restart  = 1'b1;
          bank_capture = 1'b1;
          st_nxt       = ST_ER_WIN;
        end
        ST_ER_WIN: begin
          if (wr_data == D_ERS_OK && same_bank) begin
            blk_n       = 1'b1;
            win_restart = 1'b1;
            st_nxt      = ST_ER_WIN;
          end else begin
            abort_n = 1'b1;
          end
        end
        ST_BYP: begin
          if (wr_data == D_PGM)          st_nxt = ST_BYP_PGM;
          else if (wr_data == D_BYP_OUT) st_nxt = ST_BYP_OUT;
          else                           st_nxt = ST_BYP;
        end
        ST_BYP_PGM: begin
          prog_n = 1'b1;
          st_nxt = ST_BYP;
        end
        ST_BYP_OUT: st_nxt = (wr_data == D_BYP_OK) ? ST_ARRAY : ST_BYP;
        default: st_nxt = ST_ARRAY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= ST_ARRAY;
      prog_req       <= 1'b0;
      erase_blk_req  <= 1'b0;
      erase_go       <= 1'b0;
      erase_abort    <= 1'b0;
      prog_addr      <= '0;
      prog_data      <= '0;
      erase_blk_addr <= '0;
    end else begin
      st            <= st_nxt;
      prog_req      <= prog_n;
      erase_blk_req <= blk_n;
      erase_go      <= go_n;
      erase_abort   <= abort_n;
      if (prog_n) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
      if (blk_n) erase_blk_addr <= wr_addr;
    end
  end

  assign mode_cfi      = (st == ST_QUERY);
  assign erase_pending = (st == ST_ER_WIN);
  assign mode_bypass   = (st == ST_BYP) || (st == ST_BYP_PGM) || (st == ST_BYP_OUT);
  assign mode_array    = !(mode_cfi || erase_pending || mode_bypass);

  // R1: exactly one mode indication at a time
  p_one_mode_r1: assert property (@(posedge clk) disable iff (rst)
    $countones({mode_array, mode_cfi, mode_bypass, erase_pending}) == 1);
  // R5: a program request never lasts two cycles
  p_prog_single_r5: assert property (@(posedge clk) disable iff (rst)
    prog_req |=> !prog_req);
  // R8: an accepted block always leaves the window open
  p_blk_opens_r8: assert property (@(posedge clk) disable iff (rst)
    erase_blk_req |-> erase_pending);
  // R9: erase starts only out of an open window
  p_go_from_window_r9: assert property (@(posedge clk) disable iff (rst)
    erase_go |-> ($past(erase_pending) && mode_array));
  // R10: an abort lands in read-array mode
  p_abort_to_array_r10: assert property (@(posedge clk) disable iff (rst)
    erase_abort |-> mode_array);
  // R11: at most one request pulse per cycle
  p_pulse_excl_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_req, erase_blk_req, erase_go, erase_abort}));
endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
  localparam int AW = 12;
  localparam int WIN = 8;
  localparam logic [AW-1:0] BOUND = 12'h800;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic mode_array, mode_cfi, mode_bypass, erase_pending;
  logic prog_req, erase_blk_req, erase_go, erase_abort;
  logic [AW-1:0] prog_addr, erase_blk_addr;
  logic [15:0] prog_data;

  int n_chk = 0, n_fail = 0;
  int c_prog = 0, c_blk = 0, c_go = 0, c_abort = 0;

  always #10 clk = ~clk;

  flash_cmd_decoder #(.AW(AW), .WIN_CYCLES(WIN), .BANK_BOUND(BOUND)) i_flash_cmd_decoder (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_array(mode_array), .mode_cfi(mode_cfi), .mode_bypass(mode_bypass),
    .erase_pending(erase_pending), .prog_req(prog_req), .prog_addr(prog_addr),
    .prog_data(prog_data), .erase_blk_req(erase_blk_req), .erase_blk_addr(erase_blk_addr),
    .erase_go(erase_go), .erase_abort(erase_abort));

  always @(negedge clk) if (!rst) begin
    if (prog_req)      c_prog++;
    if (erase_blk_req) c_blk++;
    if (erase_go)      c_go++;
    if (erase_abort)   c_abort++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic unlock();
    wr(12'h555, 16'h00AA);
    wr(12'h2AA, 16'h0055);
  endtask

  task automatic erase_first(input logic [AW-1:0] blk);
    unlock();
    wr(12'h555, 16'h0080);
    unlock();
    wr(blk, 16'h0030);
  endtask

  logic [3:0] modes;
  assign modes = {mode_array, mode_cfi, mode_bypass, erase_pending};

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int p0, b0, g0, a0;
    idle(2);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk(modes == 4'b1000 && !prog_req && !erase_go, "R1 reset modes", modes, 4'b1000);

    // R5 program sequence
    p0 = c_prog;
    unlock(); wr(12'h555, 16'h00A0);
    chk(c_prog == p0, "R5 no request before data", c_prog - p0, 0);
    wr(12'h9AB, 16'hBEEF);
    chk(c_prog == p0 + 1, "R5 prog pulse count", c_prog - p0, 1);
    chk(prog_addr == 12'h9AB && prog_data == 16'hBEEF, "R5 prog addr/data",
        {prog_addr, prog_data}, {12'h9AB, 16'hBEEF});

    // R2 only the low 11 address bits matter
    p0 = c_prog;
    wr(12'hD55, 16'h00AA); wr(12'hAAA, 16'h0055); wr(12'hD55, 16'h00A0); wr(12'h001, 16'h1234);
    chk(c_prog == p0 + 1 && prog_data == 16'h1234, "R2 upper bits ignored", prog_data, 16'h1234);

    // R2/R5/R6/R11 sweep of every third-cycle command byte
    for (int c = 0; c < 256; c++) begin
      p0 = c_prog;
      unlock();
      wr(12'h555, 16'(c));
      if (c == 'h20) begin
        chk(modes == 4'b0010 && c_prog == p0, "R6 sweep bypass entry", modes, 4'b0010);
        wr(12'h000, 16'h0090); wr(12'h000, 16'h0000);
      end else if (c == 'hA0) begin
        wr(12'h123, 16'h5A5A);
        chk(c_prog == p0 + 1 && mode_array, "R5 sweep program", c_prog - p0, 1);
      end else begin
        if (c == 'h80) wr(12'h000, 16'h00F0);
        chk(modes == 4'b1000 && c_prog == p0, "R11 sweep other byte", {c[7:0], modes}, {c[7:0], 4'b1000});
      end
    end

    // R4 query mode and R3 return
    wr(12'h3C3, 16'h0098);
    chk(modes == 4'b0100, "R4 query entered", modes, 4'b0100);
    idle(6);
    chk(modes == 4'b0100, "R4 query held", modes, 4'b0100);
    wr(12'h000, 16'h00F0);
    chk(modes == 4'b1000, "R3 F0 to array", modes, 4'b1000);
    wr(12'h000, 16'h00F0);
    chk(modes == 4'b1000, "R3 F0 from array", modes, 4'b1000);
    p0 = c_prog;
    wr(12'h000, 16'h0098); unlock(); wr(12'h555, 16'h00A0); wr(12'h044, 16'h0F0F);
    chk(c_prog == p0 + 1 && prog_addr == 12'h044, "R4 next write decoded", c_prog - p0, 1);

    // R11 broken sequences
    p0 = c_prog;
    wr(12'h554, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h00A0); wr(12'h010, 16'h1111);
    chk(c_prog == p0 && mode_array, "R11 wrong first address", c_prog - p0, 0);
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0054); wr(12'h555, 16'h00A0); wr(12'h010, 16'h1111);
    chk(c_prog == p0 && mode_array, "R11 wrong second data", c_prog - p0, 0);
    unlock(); wr(12'h555, 16'h0080); wr(12'h555, 16'h00AA); wr(12'h2AB, 16'h0055); wr(12'h100, 16'h0030);
    chk(c_blk == 0 && modes == 4'b1000, "R11 broken erase unlock", c_blk, 0);

    // R6 bypass programming, R7 exit
    p0 = c_prog;
    unlock(); wr(12'h555, 16'h0020);
    wr(12'h000, 16'h00A0); wr(12'h200, 16'h0001);
    wr(12'h000, 16'h00A0); wr(12'h201, 16'h0002);
    chk(c_prog == p0 + 2 && prog_addr == 12'h201 && prog_data == 16'h0002 && mode_bypass,
        "R6 bypass two programs", c_prog - p0, 2);
    wr(12'h000, 16'h0055);
    chk(modes == 4'b0010 && c_prog == p0 + 2, "R6 stray write ignored", modes, 4'b0010);
    wr(12'h000, 16'h0090); wr(12'h000, 16'h0012);
    chk(modes == 4'b0010, "R7 bad confirm keeps bypass", modes, 4'b0010);
    wr(12'h000, 16'h0090); wr(12'h000, 16'h0000);
    chk(modes == 4'b1000, "R7 bypass exit", modes, 4'b1000);

    // R8 single block, R9 timing
    b0 = c_blk; g0 = c_go;
    erase_first(12'h100);
    chk(c_blk == b0 + 1 && erase_blk_addr == 12'h100 && erase_pending, "R8 first block",
        erase_blk_addr, 12'h100);
    idle(WIN - 1);
    chk(!erase_go && erase_pending, "R9 window still open", erase_go, 0);
    idle(1);
    chk(erase_go && mode_array, "R9 erase start timing", erase_go, 1);
    idle(1);
    chk(c_go == g0 + 1, "R9 one start pulse", c_go - g0, 1);

    // R9 window restart on second block
    b0 = c_blk; g0 = c_go;
    erase_first(12'h100);
    idle(3);
    wr(12'h200, 16'h0030);
    chk(c_blk == b0 + 2 && erase_blk_addr == 12'h200, "R9 second block added", c_blk - b0, 2);
    idle(WIN - 1);
    chk(!erase_go && erase_pending && c_go == g0, "R9 window restarted", c_go - g0, 0);
    idle(1);
    chk(erase_go, "R9 start after restart", erase_go, 1);
    idle(2);

    // R10 other bank aborts
    a0 = c_abort; g0 = c_go;
    erase_first(12'h100);
    wr(12'h900, 16'h0030);
    chk(c_abort == a0 + 1 && modes == 4'b1000, "R10 other bank abort", c_abort - a0, 1);
    idle(WIN + 3);
    chk(c_go == g0, "R10 no start after abort", c_go - g0, 0);
    // R10 upper bank on its own is fine
    b0 = c_blk;
    erase_first(12'h900);
    wr(12'hA00, 16'h0030);
    idle(WIN + 2);
    chk(c_blk == b0 + 2 && c_go == g0 + 1, "R10 upper bank pair", c_go - g0, 1);
    // R10 other write in window aborts
    a0 = c_abort;
    erase_first(12'h100);
    wr(12'h100, 16'h00B0);
    idle(WIN + 2);
    chk(c_abort == a0 + 1 && c_go == g0 + 1 && mode_array, "R10 foreign write aborts",
        c_abort - a0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule